// File: doc/BRIEF.md
# Message-Signalled Interrupt Controller

This block gathers up to 32 level interrupt lines from the peripherals of a multi-function I/O chip. It holds five 32-bit registers behind a big-endian slave register port that takes 1- to 4-byte accesses. A register for each of the request, mask, pending, control and target-address functions sits on that port. A rising edge on a source line sets its pending bit. If the source is also enabled in the mask, the edge sets its request bit. No interrupt wire goes to the processor. Instead, the block sends a memory-write message on a master write port with a valid/ready handshake.

Each message carries a target address and a data value. The target address is the address register with its five low bits cleared. The data value is those five low bits, which name the processor's interrupt slot. While the bus-error bit of the control register is set, messages are held back, but pending and request capture go on as usual. A message that cannot leave at once waits in a small queue. If the queue is full, the message is counted in a deferred counter and enters the queue when space frees.

The source wiring is fixed: serial 5, parallel 7, network 8, SCSI 9, audio 13, the chip's own events 14, and keyboard plus mouse share 26.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset the request, mask, pending and control registers read zero, the address register reads the parameter ADDR_RESET (default 0x0001_2343), and msg_valid is low.
- R2: A 0-to-1 change on irq_in[n] sets pending bit n once. A line held high does not set the bit again after the bit has been cleared.
- R3: The request register (word 0, byte offset 0x00) gains bit n only on a rising edge of source n while mask bit n is set. Bits stay set until reset. Writes to it are ignored.
- R4: Any read or any write of the pending register (offset 0x08) clears it, whatever the size or data. A read returns the value held before the clear. An edge that arrives in the same cycle as the clear is kept.
- R5: The control register (offset 0x0C) keeps only bit 8, the bus-error bit. A 4-byte read returns bit 8 and zero in every other bit.
- R6: The mask register (offset 0x04) keeps only the legal bits 5, 7, 8, 9, 13, 14, 16 to 21 and 26 (LEGAL_MASK, default 0x043F_63A0). Other written bits are dropped.
- R7: In each cycle where at least one masked rising edge occurs and control bit 8 is clear, one message is issued. Its msg_addr is the address register (offset 0x10) AND ~31 and its msg_data is the address register AND 31. Simultaneous edges yield one message. With control bit 8 set, no message is issued.
- R8: While msg_ready is low, msg_valid, msg_addr and msg_data hold steady. Up to FIFO_DEPTH (4) messages queue in order, and further ones are deferred rather than lost. Every message is delivered in order once msg_ready rises.
- R9: Accesses are big-endian. reg_addr[1:0] is the first byte, where byte 0 is bits 31:24. reg_size+1 is the byte count. Read and write data are right-justified. Bytes past the end of the word read as zero and are dropped on a write.
- R10: Word offsets 0x14 to 0x1F read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_SRC | Level interrupt lines, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Byte address within the register window |
| reg_size | input | 2 | Access size minus one, in bytes |
| reg_wdata | input | 32 | Right-justified write data |
| reg_rdata | output | 32 | Right-justified read data, valid while reg_rd is high |
| msg_valid | output | 1 | Interrupt message available |
| msg_ready | input | 1 | Message accepted by the fabric |
| msg_addr | output | 32 | Message target address |
| msg_data | output | 32 | Message data (interrupt slot) |

## Verification
A behavioural model with an unbounded message queue is compared against msg_valid, msg_addr and msg_data on every cycle. The input patterns test different failure modes:
- **Single pulses on masked and on unmasked lines** separate pending capture from request capture and message issue.
- **A line held high for many cycles** separates edge detection from level sensing.
- **A read of the pending register in the same cycle as a new edge** shows whether the set or the clear wins.
- **Edges on two sources in one cycle** show that simultaneous edges yield one message.
- **A burst of eight events against a stalled msg_ready, with the address changed mid-burst,** exercises queue order, the deferred path and output stability.
- **Partial and word-overrunning accesses** pin down the big-endian byte placement.

// File: rtl/irqm_pkg.sv
// Shared constants, types and byte-lane helpers for the interrupt message
// controller. Assumes a 32-bit register word and big-endian byte numbering
// (byte 0 is the most significant byte of the word).
package irqm_pkg;

    localparam int WORD_W     = 32;
    localparam int BYTE_N     = WORD_W / 8;
    localparam int SLOT_W     = 5;
    localparam int BUSERR_BIT = 8;
    localparam logic [WORD_W-1:0] LEGAL_DEFAULT = 32'h043F_63A0;

    typedef enum logic [2:0] {
        RS_REQ  = 3'd0,
        RS_MASK = 3'd1,
        RS_PEND = 3'd2,
        RS_CTRL = 3'd3,
        RS_ADDR = 3'd4,
        RS_NONE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } irq_msg_t;

    // Pull sz+1 bytes starting at big-endian byte off, right-justified.
    function automatic logic [WORD_W-1:0] be_extract(input logic [WORD_W-1:0] word,
                                                     input logic [1:0] off,
                                                     input logic [1:0] sz);
        logic [WORD_W-1:0] r;
        int idx;
        r = '0;
        for (int k = 0; k < BYTE_N; k++) begin
            idx = int'(off) + int'(sz) - k;
            if (k <= int'(sz) && idx < BYTE_N)
                r[8*k +: 8] = word[8*(BYTE_N-1-idx) +: 8];
        end
        return r;
    endfunction

    // Merge right-justified write bytes into the word at big-endian byte off.
    function automatic logic [WORD_W-1:0] be_merge(input logic [WORD_W-1:0] word,
                                                   input logic [WORD_W-1:0] wdata,
                                                   input logic [1:0] off,
                                                   input logic [1:0] sz);
        logic [WORD_W-1:0] w;
        w = word;
        for (int i = 0; i < BYTE_N; i++) begin
            if (i >= int'(off) && i <= int'(off) + int'(sz))
                w[8*(BYTE_N-1-i) +: 8] = wdata[8*(int'(off) + int'(sz) - i) +: 8];
        end
        return w;
    endfunction

endpackage

// File: rtl/irqm_edge.sv
// Rising-edge detector for the interrupt lines.
// Assumes the lines are already synchronous to clk. A line that is high when
// reset is released counts as one rising edge.
module irqm_edge #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_q;

    // Remember last cycle's line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;

endmodule

// File: rtl/irqm_regs.sv
// Register file and slave-port decode: request, mask, pending, control and
// target address. It also decides when a message is due.
// Assumes one access per cycle, with reg_rd and reg_wr not both set. Read data
// is combinational, and side effects of a read land on the closing edge.
module irqm_regs
    import irqm_pkg::*;
#(
    parameter int                REG_AW     = 5,
    parameter logic [WORD_W-1:0] LEGAL      = LEGAL_DEFAULT,
    parameter logic [WORD_W-1:0] ADDR_RESET = 32'h0001_2343
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] rise,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [WORD_W-1:0] mask_q,
    output logic [WORD_W-1:0] req_q,
    output logic [WORD_W-1:0] pend_q,
    output logic              msg_req,
    output irq_msg_t          msg_word
);

    localparam int WIDX_W = REG_AW - 2;

    logic [WIDX_W-1:0] widx;
    logic [1:0]        boff;
    reg_sel_e          sel;
    logic              buserr_q;
    logic [WORD_W-1:0] areg_q;
    logic [WORD_W-1:0] cur_word;
    logic [WORD_W-1:0] merged;
    logic              pend_hit;
    logic [WORD_W-1:0] masked_rise;

    assign widx = bus_addr[REG_AW-1:2];
    assign boff = bus_addr[1:0];

    // Map the word index onto a register.
    always_comb begin
        case (widx)
            WIDX_W'(0): sel = RS_REQ;
            WIDX_W'(1): sel = RS_MASK;
            WIDX_W'(2): sel = RS_PEND;
            WIDX_W'(3): sel = RS_CTRL;
            WIDX_W'(4): sel = RS_ADDR;
            default:    sel = RS_NONE;
        endcase
    end

    // Current contents of the addressed register as seen by the bus.
    always_comb begin
        case (sel)
            RS_REQ:  cur_word = req_q;
            RS_MASK: cur_word = mask_q;
            RS_PEND: cur_word = pend_q;
            RS_CTRL: cur_word = WORD_W'(buserr_q) << BUSERR_BIT;
            RS_ADDR: cur_word = areg_q;
            default: cur_word = '0;
        endcase
    end

    assign merged      = be_merge(cur_word, bus_wdata, boff, bus_size);
    assign bus_rdata   = bus_rd ? be_extract(cur_word, boff, bus_size) : '0;
    assign pend_hit    = (bus_rd | bus_wr) && (sel == RS_PEND);
    assign masked_rise = rise & mask_q;

    // Mask register, illegal bits dropped on write.
    always_ff @(posedge clk) begin
        if (!rst_n)                          mask_q <= '0;
        else if (bus_wr && sel == RS_MASK)   mask_q <= merged & LEGAL;
    end

    // Control register: only the bus-error bit is kept.
    always_ff @(posedge clk) begin
        if (!rst_n)                          buserr_q <= 1'b0;
        else if (bus_wr && sel == RS_CTRL)   buserr_q <= merged[BUSERR_BIT];
    end

    // Message target address register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          areg_q <= ADDR_RESET;
        else if (bus_wr && sel == RS_ADDR)   areg_q <= merged;
    end

    // Request capture: sticky, bus writes ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_q | masked_rise;
    end

    // Pending capture: any access clears, a same-cycle edge survives.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_hit ? '0 : pend_q) | rise;
    end

    assign msg_req       = (|masked_rise) & ~buserr_q;
    assign msg_word.addr = {areg_q[WORD_W-1:SLOT_W], SLOT_W'(0)};
    assign msg_word.data = {(WORD_W-SLOT_W)'(0), areg_q[SLOT_W-1:0]};

endmodule

// File: rtl/irqm_msg_queue.sv
// Outgoing message queue with an overflow counter.
// Assumes a message request may come every cycle. When the FIFO is full, each
// request increments a deferred counter (saturating), and the count drains into
// the FIFO with the message current at drain time. While the counter is
// non-zero, new requests also go through it, which keeps the order.
module irqm_msg_queue
    import irqm_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int DEFER_W = 6
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     evt,
    input  irq_msg_t evt_msg,
    output logic     out_valid,
    output irq_msg_t out_msg,
    input  logic     out_ready
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [DEFER_W-1:0] DEFER_MAX = {DEFER_W{1'b1}};

    irq_msg_t            slots [DEPTH];
    logic [PTR_W-1:0]    wr_ptr, rd_ptr;
    logic [CNT_W-1:0]    cnt_q;
    logic [DEFER_W-1:0]  defer_q, defer_d;
    logic                full, push, pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign out_valid = (cnt_q != '0);
    assign pop       = out_valid & out_ready;
    assign out_msg   = slots[rd_ptr];

    // Choose between a direct push, a drain of deferred work, or a deferral.
    always_comb begin
        push    = 1'b0;
        defer_d = defer_q;
        if (defer_q == '0) begin
            push = evt & ~full;
            if (evt && full) defer_d = defer_q + DEFER_W'(1);
        end else begin
            push = ~full;
            if (evt && !push && defer_q != DEFER_MAX) defer_d = defer_q + DEFER_W'(1);
            else if (!evt && push)                    defer_d = defer_q - DEFER_W'(1);
        end
    end

    // One storage slot per entry, written when the write pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                              slots[i] <= '0;
            else if (push && wr_ptr == PTR_W'(i))    slots[i] <= evt_msg;
        end
    end

    // Pointers, occupancy and deferred count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            cnt_q   <= '0;
            defer_q <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            cnt_q   <= cnt_q + CNT_W'(push) - CNT_W'(pop);
            defer_q <= defer_d;
        end
    end

endmodule

// File: rtl/irq_msg_ctrl.sv
// Top of the interrupt message controller: edge detection, register file and
// message queue. Assumes NUM_SRC <= 32, REG_AW >= 5 and synchronous inputs.
module irq_msg_ctrl
    import irqm_pkg::*;
#(
    parameter int                NUM_SRC    = 32,
    parameter int                REG_AW     = 5,
    parameter int                FIFO_DEPTH = 4,
    parameter int                DEFER_W    = 6,
    parameter logic [WORD_W-1:0] LEGAL_MASK = LEGAL_DEFAULT,
    parameter logic [WORD_W-1:0] ADDR_RESET = 32'h0001_2343
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [1:0]         reg_size,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [31:0]        msg_addr,
    output logic [31:0]        msg_data
);

    logic [NUM_SRC-1:0] rise_n;
    logic [WORD_W-1:0]  rise_w;
    logic [WORD_W-1:0]  mask_q, req_q, pend_q;
    logic               msg_req;
    irq_msg_t           msg_word, head_msg;

    irqm_edge #(.N(NUM_SRC)) edge_i (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (irq_in),
        .rise (rise_n)
    );

    assign rise_w = WORD_W'(rise_n);

    irqm_regs #(
        .REG_AW    (REG_AW),
        .LEGAL     (LEGAL_MASK),
        .ADDR_RESET(ADDR_RESET)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise_w),
        .bus_wr   (reg_wr),
        .bus_rd   (reg_rd),
        .bus_addr (reg_addr),
        .bus_size (reg_size),
        .bus_wdata(reg_wdata),
        .bus_rdata(reg_rdata),
        .mask_q   (mask_q),
        .req_q    (req_q),
        .pend_q   (pend_q),
        .msg_req  (msg_req),
        .msg_word (msg_word)
    );

    irqm_msg_queue #(
        .DEPTH  (FIFO_DEPTH),
        .DEFER_W(DEFER_W)
    ) queue_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (msg_req),
        .evt_msg  (msg_word),
        .out_valid(msg_valid),
        .out_msg  (head_msg),
        .out_ready(msg_ready)
    );

    assign msg_addr = head_msg.addr;
    assign msg_data = head_msg.data;

endmodule

// File: rtl/irq_msg_ctrl_chk.sv
// Property checker for irq_msg_ctrl, attached by bind. It observes ports and
// the register outputs that the register file hands to the rest of the block.
module irq_msg_ctrl_chk #(
    parameter int          NUM_SRC = 32,
    parameter int          REG_AW  = 5,
    parameter logic [31:0] LEGAL   = 32'h043F_63A0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_in,
    input logic               reg_rd,
    input logic               reg_wr,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [1:0]         reg_size,
    input logic [31:0]        reg_rdata,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [31:0]        msg_addr,
    input logic [31:0]        msg_data,
    input logic [31:0]        req_q,
    input logic [31:0]        mask_q,
    input logic [31:0]        pend_q
);

    logic [31:0] irq32;
    assign irq32 = 32'(irq_in);

    // R8: a stalled message does not move or change.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

    // R7: message address is 32-byte aligned, data is a 5-bit slot.
    p_msg_format_r7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[4:0] == 5'd0) && (msg_data[31:5] == 27'd0));

    // R3: a new request bit needs the mask bit and the source line.
    p_req_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q & ~$past(req_q) & ~($past(mask_q) & $past(irq32))) == 32'd0);

    // R3: request bits never drop outside reset.
    p_req_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q & $past(req_q)) == $past(req_q));

    // R4: after an access to pending, only lines high at that access remain.
    p_pend_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd || reg_wr) && reg_addr[REG_AW-1:2] == (REG_AW-2)'(2)
        |=> (pend_q & ~$past(irq32)) == 32'd0);

    // R5: a full-word control read shows only bit 8.
    p_ctrl_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == REG_AW'(12) && reg_size == 2'd3
        |-> reg_rdata[31:9] == 23'd0 && reg_rdata[7:0] == 8'd0);

    // R6: a full-word mask read shows only legal bits.
    p_mask_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == REG_AW'(4) && reg_size == 2'd3
        |-> (reg_rdata & ~LEGAL) == 32'd0);

    // R4: pending never holds a bit for a line that has not been high.
    p_pend_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~$past(pend_q) & ~$past(irq32)) == 32'd0);

endmodule

bind irq_msg_ctrl irq_msg_ctrl_chk #(
    .NUM_SRC(NUM_SRC),
    .REG_AW (REG_AW),
    .LEGAL  (LEGAL_MASK)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_size (reg_size),
    .reg_rdata(reg_rdata),
    .msg_valid(msg_valid),
    .msg_ready(msg_ready),
    .msg_addr (msg_addr),
    .msg_data (msg_data),
    .req_q    (req_q),
    .mask_q   (mask_q),
    .pend_q   (pend_q)
);

// File: tb/irq_msg_ctrl_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural model (queue of expected messages plus
// register images) runs beside the design and is compared every clock.
module irq_msg_ctrl_tb_top;

    localparam bit [31:0] LEGAL = 32'h043F_63A0;
    localparam bit [31:0] ARST  = 32'h0001_2343;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq = '0;
    logic        b_wr = 1'b0, b_rd = 1'b0, b_ready = 1'b1;
    logic [4:0]  b_addr = '0;
    logic [1:0]  b_sz = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] rdata, ma, md;
    logic        mv;

    int checks = 0, errors = 0, n_deliv = 0;
    bit done = 1'b0;
    bit [63:0] last_msg;

    // Model state.
    bit [31:0] m_mask, m_req, m_pend, m_areg, m_prev;
    bit        m_bus;
    bit [63:0] m_q[$];

    irq_msg_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq),
        .reg_wr(b_wr), .reg_rd(b_rd), .reg_addr(b_addr), .reg_size(b_sz),
        .reg_wdata(b_wdata), .reg_rdata(rdata),
        .msg_valid(mv), .msg_ready(b_ready), .msg_addr(ma), .msg_data(md)
    );

    always #4 clk = ~clk;

    function automatic bit [31:0] tb_put(bit [31:0] w, int off, int sz, bit [31:0] d);
        bit [7:0] b[4];
        for (int i = 0; i < 4; i++) b[i] = w[31-8*i -: 8];
        for (int j = 0; j <= sz; j++) if (off + j < 4) b[off+j] = d[8*(sz-j) +: 8];
        return {b[0], b[1], b[2], b[3]};
    endfunction

    task automatic check(input string req, input bit [63:0] act, input bit [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        bit [31:0] rise, masked, old_a, tmp;
        bit old_b;
        int widx;
        if (!rst_n) begin
            m_mask = 0; m_req = 0; m_pend = 0; m_areg = ARST; m_prev = 0; m_bus = 0;
            m_q.delete();
        end else begin
            if (mv && b_ready) begin n_deliv++; last_msg = {ma, md}; end
            if (m_q.size() > 0 && b_ready) void'(m_q.pop_front());
            rise = irq & ~m_prev; m_prev = irq;
            masked = rise & m_mask; old_a = m_areg; old_b = m_bus;
            widx = int'(b_addr[4:2]);
            if (b_wr) begin
                case (widx)
                    1: m_mask = tb_put(m_mask, int'(b_addr[1:0]), int'(b_sz), b_wdata) & LEGAL;
                    3: begin
                        tmp = tb_put({23'd0, m_bus, 8'd0}, int'(b_addr[1:0]), int'(b_sz), b_wdata);
                        m_bus = tmp[8];
                    end
                    4: m_areg = tb_put(m_areg, int'(b_addr[1:0]), int'(b_sz), b_wdata);
                    default: ;
                endcase
            end
            if ((b_rd || b_wr) && widx == 2) m_pend = 0;
            m_pend |= rise;
            m_req  |= masked;
            if (masked != 0 && !old_b) m_q.push_back({old_a & ~32'h1F, old_a & 32'h1F});
        end
    end

    // Every-cycle comparison of the message port against the model (R7, R8).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8 msg_valid", 64'(mv), 64'(m_q.size() > 0));
            if (m_q.size() > 0) check("R7 message", {ma, md}, m_q[0]);
        end
    end

    task automatic wr(input bit [4:0] a, input bit [1:0] s, input bit [31:0] d);
        @(negedge clk); b_wr = 1; b_addr = a; b_sz = s; b_wdata = d;
        @(negedge clk); b_wr = 0;
    endtask

    task automatic rd(input bit [4:0] a, input bit [1:0] s, input bit [31:0] exp, input string req);
        @(negedge clk); b_rd = 1; b_addr = a; b_sz = s;
        #1 check(req, 64'(rdata), 64'(exp));
        @(negedge clk); b_rd = 0;
    endtask

    task automatic pulse(input bit [31:0] bits);
        @(negedge clk); irq = irq | bits;
        @(negedge clk); irq = irq & ~bits;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values.
        #1 check("R1 msg_valid", 64'(mv), 0);
        rd(5'h00, 3, 32'h0, "R1 req");
        rd(5'h04, 3, 32'h0, "R1 mask");
        rd(5'h08, 3, 32'h0, "R1 pend");
        rd(5'h0C, 3, 32'h0, "R1 ctrl");
        rd(5'h10, 3, ARST,  "R1 addr");
        // R6: illegal mask bits dropped.
        wr(5'h04, 3, 32'hFFFF_FFFF);
        rd(5'h04, 3, LEGAL, "R6 mask legal");
        // R3: request writes ignored.
        wr(5'h00, 3, 32'hFFFF_FFFF);
        rd(5'h00, 3, 32'h0, "R3 req write ignored");
        wr(5'h04, 3, 32'h0000_0120);
        rd(5'h04, 3, 32'h0000_0120, "R6 mask 5,8");
        // R7: masked pulse gives one message.
        base = n_deliv;
        pulse(32'h20); idle(3);
        check("R7 one message", 64'(n_deliv - base), 1);
        check("R7 message value", last_msg, {32'h0001_2340, 32'h3});
        rd(5'h00, 3, 32'h20, "R3 req bit 5");
        rd(5'h08, 3, 32'h20, "R2 pend bit 5");
        rd(5'h08, 3, 32'h0,  "R4 read cleared");
        // R3/R7: unmasked source.
        base = n_deliv;
        pulse(32'h1); idle(3);
        check("R7 unmasked no message", 64'(n_deliv - base), 0);
        rd(5'h08, 3, 32'h1,  "R2 pend unmasked");
        rd(5'h00, 3, 32'h20, "R3 req unmasked");
        // R2: held level gives one event.
        base = n_deliv;
        @(negedge clk); irq[8] = 1;
        idle(10);
        check("R2 held single message", 64'(n_deliv - base), 1);
        rd(5'h08, 3, 32'h100, "R2 pend held");
        rd(5'h08, 3, 32'h0,   "R2 no re-set while held");
        @(negedge clk); irq[8] = 0;
        // R4: any write clears.
        pulse(32'h200); idle(1);
        wr(5'h09, 0, 32'hAA);
        rd(5'h08, 3, 32'h0, "R4 write clears");
        // R4: edge in the clearing cycle survives.
        @(negedge clk); b_rd = 1; b_addr = 5'h08; b_sz = 3; irq[13] = 1;
        #1 check("R4 read before set", 64'(rdata), 0);
        @(negedge clk); b_rd = 0; irq[13] = 0;
        rd(5'h08, 3, 32'h2000, "R4 set wins");
        // R5: control keeps only bit 8, and it blocks messages (R7).
        wr(5'h0C, 3, 32'hFFFF_FFFF);
        rd(5'h0C, 3, 32'h100, "R5 ctrl bit 8 only");
        base = n_deliv;
        pulse(32'h100); idle(3);
        check("R7 blocked", 64'(n_deliv - base), 0);
        rd(5'h00, 3, 32'h120, "R3 req while blocked");
        wr(5'h0C, 3, 32'h0);
        rd(5'h0C, 3, 32'h0, "R5 ctrl cleared");
        // R9: big-endian partial accesses.
        wr(5'h13, 0, 32'h47);
        rd(5'h10, 3, 32'h0001_2347, "R9 byte write");
        rd(5'h12, 1, 32'h2347, "R9 halfword read");
        rd(5'h11, 0, 32'h01,   "R9 byte read");
        wr(5'h10, 1, 32'h8000);
        wr(5'h13, 1, 32'hAB55);
        rd(5'h10, 3, 32'h8000_23AB, "R9 overrun write");
        rd(5'h13, 1, 32'hAB00, "R9 overrun read");
        pulse(32'h20); idle(3);
        check("R7 new address", last_msg, {32'h8000_23A0, 32'h0B});
        // R7: simultaneous edges coalesce.
        base = n_deliv;
        pulse(32'h120); idle(3);
        check("R7 simultaneous one message", 64'(n_deliv - base), 1);
        // R10: unmapped words.
        wr(5'h14, 3, 32'hFFFF_FFFF);
        rd(5'h14, 3, 32'h0, "R10 unmapped read");
        rd(5'h1C, 3, 32'h0, "R10 unmapped high");
        rd(5'h04, 3, 32'h120, "R10 mask untouched");
        rd(5'h10, 3, 32'h8000_23AB, "R10 addr untouched");
        // R8: stall, queue, defer, change address mid-burst.
        base = n_deliv;
        @(negedge clk); b_ready = 0;
        pulse(32'h20); pulse(32'h20);
        wr(5'h10, 3, 32'h0000_5555);
        repeat (6) pulse(32'h20);
        idle(4);
        check("R8 none while stalled", 64'(n_deliv - base), 0);
        check("R8 valid while stalled", 64'(mv), 1);
        @(negedge clk); b_ready = 1;
        idle(20);
        check("R8 all delivered", 64'(n_deliv - base), 8);
        check("R8 last value", last_msg, {32'h0000_5540, 32'h15});
        idle(2);
        finish_run();
    end

endmodule